// File: doc/BRIEF.md
# Iterative XOR/carry-word adder

This block adds two unsigned operands over several clock cycles instead of through one carry chain. On each step the two operand registers feed a bitwise XOR, which gives a partial sum without carries, and a bitwise AND shifted up one place, which gives the carries still to be added. The two words are captured in a sum register and a carry register. If the carry word is not zero, it and the partial sum are written back into the operand registers and the step runs again. When the carry register holds zero, the sum register holds the full result.

The user pulses `start` with both operands present. Some cycles later `done` is high for a single cycle, and `result` holds the sum, one bit wider than the operands. The result stays unchanged until the next accepted start. A start pulse seen while a run is in progress is ignored. The zero test on the carry register can be built as a reduction or as a linear OR chain, chosen by a parameter.

Top module: `xsa_adder`

## Requirements
- R1: After reset `done` is 0 and `result` is 0.
- R2: When `done` is high, `result` equals the unsigned sum of the two operands captured at the accepted start, in OPW+1 bits.
- R3: `done` is high for exactly one cycle per accepted start, and only at the end of a run.
- R4: If the start is sampled at clock edge 0 and the run needs k XOR/AND evaluations, `done` is high after edge 2k. k never exceeds OPW+1, so a run never takes more than 2(OPW+1) edges.
- R5: If the bitwise AND of the operands is zero, the run ends after one evaluation (`done` after edge 2) and `result` is their XOR.
- R6: Operands 1011 and 0110 need four evaluations (the carry word is shifted three times while still non-zero). `done` comes after edge 8 with `result` = 10001 (17).
- R7: After `done`, `result` stays stable until the cycle after the next accepted start.
- R8: A `start` pulse or operand change during a run has no effect: the run keeps its original operands and timing.
- R9: An all-ones operand plus one needs OPW+1 evaluations, so `done` comes after edge 2(OPW+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| addend_a | input | OPW | First unsigned operand |
| addend_b | input | OPW | Second unsigned operand |
| result | output | OPW+1 | Sum, valid while `done` is high and held until the next run |
| done | output | 1 | One-cycle completion flag |

## Verification
The checker assumes that operands matter only at the edge where an idle block samples `start`. It captures its reference sum at that edge and ignores any later value on the operand pins. It also assumes that `start` is a clean synchronous level, so a start during the completion cycle counts as ignored, just as a start in mid-run does. The stimulus changes inputs only on falling edges. It includes one deliberate mid-run start with different operands, so that the checker's capture timing is exercised. It never holds `start` high across the completion cycle.

// File: rtl/xsa_pkg.sv
package xsa_pkg;

   typedef enum logic [1:0] {
      XSA_IDLE = 2'd0,
      XSA_EVAL = 2'd1,
      XSA_FEED = 2'd2,
      XSA_FIN  = 2'd3
   } xsa_state_e;

   // Zero-detector build options
   localparam int XSA_ZD_REDUCE = 0;
   localparam int XSA_ZD_CHAIN  = 1;

endpackage

// File: rtl/xsa_en_reg.sv
module xsa_en_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (W >= 1) else $error("xsa_en_reg: W must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/xsa_step_logic.sv
module xsa_step_logic #(
   parameter int W = 9
) (
   input  logic [W-1:0] op_x,
   input  logic [W-1:0] op_y,
   output logic [W-1:0] part_sum,
   output logic [W-1:0] carry_word
);
   initial assert (W >= 2) else $error("xsa_step_logic: W must be at least 2");

   assign carry_word[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign part_sum[i] = op_x[i] ^ op_y[i];
      if (i < W - 1) begin : g_carry
         assign carry_word[i+1] = op_x[i] & op_y[i];
      end
   end
endmodule

// File: rtl/xsa_zero_detect.sv
module xsa_zero_detect #(
   parameter int W     = 9,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] vec,
   output logic         is_zero
);
   import xsa_pkg::*;

   initial assert (W >= 1) else $error("xsa_zero_detect: W must be at least 1");
   initial assert (STYLE == XSA_ZD_REDUCE || STYLE == XSA_ZD_CHAIN)
      else $error("xsa_zero_detect: unknown STYLE");

   if (STYLE == XSA_ZD_CHAIN) begin : g_chain
      logic [W-1:0] any_set;
      assign any_set[0] = vec[0];
      for (genvar i = 1; i < W; i++) begin : g_link
         assign any_set[i] = any_set[i-1] | vec[i];
      end
      assign is_zero = ~any_set[W-1];
   end else begin : g_reduce
      assign is_zero = ~(|vec);
   end
endmodule

// File: rtl/xsa_ctrl.sv
module xsa_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic carry_zero,
   output logic load_ops,
   output logic use_feedback,
   output logic load_words,
   output logic finished
);
   import xsa_pkg::*;

   xsa_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= XSA_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d      = state_q;
      load_ops     = 1'b0;
      use_feedback = 1'b0;
      load_words   = 1'b0;
      unique case (state_q)
         XSA_IDLE: begin
            if (start) begin
               load_ops = 1'b1;
               state_d  = XSA_EVAL;
            end
         end
         XSA_EVAL: begin
            load_words = 1'b1;
            state_d    = XSA_FEED;
         end
         XSA_FEED: begin
            if (carry_zero) begin
               state_d = XSA_FIN;
            end else begin
               load_ops     = 1'b1;
               use_feedback = 1'b1;
               state_d      = XSA_EVAL;
            end
         end
         XSA_FIN: state_d = XSA_IDLE;
         default: state_d = XSA_IDLE;
      endcase
   end

   assign finished = (state_q == XSA_FIN);
endmodule

// File: rtl/xsa_adder.sv
module xsa_adder #(
   parameter int OPW      = 8,
   parameter int ZD_STYLE = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [OPW-1:0] addend_a,
   input  logic [OPW-1:0] addend_b,
   output logic [OPW:0]   result,
   output logic           done
);
   localparam int RW = OPW + 1;

   initial assert (OPW >= 1) else $error("xsa_adder: OPW must be at least 1");

   logic          load_ops, use_feedback, load_words, carry_zero;
   logic [RW-1:0] opx_q, opy_q, opx_d, opy_d;
   logic [RW-1:0] psum_c, cword_c, psum_q, cword_q;

   // Operand input selectors: external addends or fed-back words
   always_comb begin
      if (use_feedback) begin
         opx_d = psum_q;
         opy_d = cword_q;
      end else begin
         opx_d = {1'b0, addend_a};
         opy_d = {1'b0, addend_b};
      end
   end

   xsa_en_reg #(.W(RW)) u_opx (
      .clk(clk), .rst_n(rst_n), .en(load_ops), .d(opx_d), .q(opx_q)
   );
   xsa_en_reg #(.W(RW)) u_opy (
      .clk(clk), .rst_n(rst_n), .en(load_ops), .d(opy_d), .q(opy_q)
   );

   xsa_step_logic #(.W(RW)) u_step (
      .op_x(opx_q), .op_y(opy_q), .part_sum(psum_c), .carry_word(cword_c)
   );

   xsa_en_reg #(.W(RW)) u_psum (
      .clk(clk), .rst_n(rst_n), .en(load_words), .d(psum_c), .q(psum_q)
   );
   xsa_en_reg #(.W(RW)) u_cword (
      .clk(clk), .rst_n(rst_n), .en(load_words), .d(cword_c), .q(cword_q)
   );

   xsa_zero_detect #(.W(RW), .STYLE(ZD_STYLE)) u_zd (
      .vec(cword_q), .is_zero(carry_zero)
   );

   xsa_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .carry_zero(carry_zero),
      .load_ops(load_ops), .use_feedback(use_feedback),
      .load_words(load_words), .finished(done)
   );

   assign result = psum_q;
endmodule

// File: rtl/xsa_adder_chk.sv
module xsa_adder_chk #(
   parameter int OPW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [OPW-1:0] addend_a,
   input logic [OPW-1:0] addend_b,
   input logic [OPW:0]   result,
   input logic           done
);
   localparam int RW = OPW + 1;
   localparam int CW = $clog2(2 * RW + 4) + 1;

   logic          busy, disjoint, hold;
   logic [CW-1:0] cnt;
   logic [RW-1:0] ref_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         ref_sum  <= '0;
         disjoint <= 1'b0;
      end else if (!busy && start) begin
         busy     <= 1'b1;
         cnt      <= CW'(1);
         ref_sum  <= {1'b0, addend_a} + {1'b0, addend_b};
         disjoint <= ((addend_a & addend_b) == '0);
      end else if (busy && done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold <= 1'b0;
      else if (done)             hold <= 1'b1;
      else if (start && !busy)   hold <= 1'b0;
   end

   a_r2_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result == ref_sum);

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r3_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r4_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> int'(cnt) <= 2 * RW + 1);

   a_r5_disjoint_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (done && disjoint) |-> int'(cnt) == 3);

   a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(result));
endmodule

bind xsa_adder xsa_adder_chk #(.OPW(OPW)) u_xsa_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .addend_a(addend_a),
   .addend_b(addend_b), .result(result), .done(done)
);

// File: tb/xsa_adder_bench.sv
module xsa_adder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int RW = W + 1;
   localparam int NV = 10;

   localparam logic [W-1:0] VEC_A [NV] = '{8'h00, 8'hFF, 8'h0B, 8'h55, 8'hFF,
                                           8'h80, 8'h3C, 8'h7F, 8'h01, 8'hA5};
   localparam logic [W-1:0] VEC_B [NV] = '{8'h00, 8'hFF, 8'h06, 8'hAA, 8'h01,
                                           8'h80, 8'h0F, 8'h7F, 8'h01, 8'h5A};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  addend_a = '0;
   logic [W-1:0]  addend_b = '0;
   logic [RW-1:0] result;
   logic          done;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xsa_adder #(.OPW(W)) u_xsa_adder (
      .clk(clk), .rst_n(rst_n), .start(start), .addend_a(addend_a),
      .addend_b(addend_b), .result(result), .done(done)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Runs one addition; returns edges after the start edge until done.
   // poke_at > 0 pulses start with other operands at that count.
   task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int poke_at, output int lat);
      @(negedge clk);
      addend_a = a; addend_b = b; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      for (int i = 0; i < 64; i++) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (poke_at > 0 && lat == poke_at) begin
            addend_a = ~a; addend_b = 8'h33; start = 1'b1;
         end else if (start) begin
            start = 1'b0;
         end
         if (done) break;
      end
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL R4: actual no done expected done within %0d", 2 * RW);
         lat = -1;
      end
   endtask

   initial begin
      int lat;
      logic [RW-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done", done, 0);
      check("R1 result", result, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R2 sums, R4 bound, R3 single-cycle done
      for (int v = 0; v < NV; v++) begin
         run_add(VEC_A[v], VEC_B[v], 0, lat);
         check("R2 sum", result, {1'b0, VEC_A[v]} + {1'b0, VEC_B[v]});
         check("R4 bound", (lat > 0 && lat <= 2 * RW && lat % 2 == 0), 1);
         @(negedge clk);
         check("R3 done drops", done, 0);
      end

      // R5: disjoint operands finish after one evaluation
      run_add(8'hF0, 8'h0C, 0, lat);
      check("R5 latency", lat, 2);
      check("R5 result", result, 9'h0FC);

      // R6: 1011 + 0110
      run_add(8'h0B, 8'h06, 0, lat);
      check("R6 latency", lat, 8);
      check("R6 result", result, 9'b0_0001_0001);

      // R7: result held while idle, operands wiggling
      held = result;
      @(negedge clk); addend_a = 8'h12; addend_b = 8'h34;
      repeat (5) @(negedge clk);
      check("R7 hold", result, held);
      check("R7 done low", done, 0);

      // R8: start during run ignored (0x03 + 0x05 takes four evaluations)
      run_add(8'h03, 8'h05, 3, lat);
      check("R8 latency", lat, 8);
      check("R8 result", result, 9'd8);

      // R9: worst case all ones plus one
      run_add(8'hFF, 8'h01, 0, lat);
      check("R9 latency", lat, 2 * RW);
      check("R9 result", result, 9'h100);

      // R1: reset mid-run clears outputs
      @(negedge clk);
      addend_a = 8'hFF; addend_b = 8'hFF; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset done", done, 0);
      check("R1 reset result", result, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule